// File: doc/BRIEF.md
# General-purpose I/O port with change interrupt

This block is an 8-bit bidirectional I/O port behind a small register bus. Software sets each pin's direction, loads an output latch and reads the pin levels back. The block drives three per-pin pad controls: the drive value, the output enable and the weak pull-up enable. It has no analog pad model and no alternate functions.

The upper four pins can raise a change interrupt. Each upper pin that is set as an input is compared with a snapshot of that pin. The snapshot is taken every time software reads or writes the port data register. Any difference sets a sticky flag. Clearing the flag alone does not end a difference. Only a port data access refreshes the snapshot and ends it, and the usual service sequence is to access the port first and then clear the flag.

Pin levels pass through a two-stage synchronizer first. The read path and the comparison both use the synchronized value.

Top module: `gpio_ioc_port`

## Requirements
- R1: The direction register resets to all ones, which makes every pin an input. Writing register address 2 loads it. A direction bit of 1 drives `pin_oe` low for that pin, and a direction bit of 0 drives `pin_oe` high from the edge after the write.
- R2: The output latch resets to zero. A write to address 0 (port data) or address 1 (latch) loads it from `bus_wdata`. `pin_out` always shows the latch.
- R3: Read data is combinational from `bus_addr`. Address 1 returns the latch, address 2 returns the direction register and address 3 returns zero.
- R4: Address 0 returns the pin levels delayed by two clock edges, through the synchronizer. It never returns the latch.
- R5: `pu_ctl_n` is active low and is registered on each edge. `pin_pu[i]` is high only when the registered control is 0 and direction bit i is 1. An output pin therefore never has its pull-up on.
- R6: Reset leaves the registered pull-up control in the disabled state, so `pin_pu` is all zeros until `pu_ctl_n` has been sampled low.
- R7: Only pins 7..4 take part in change detection, and only while their direction bit is 1. A difference between such a synchronized pin and its snapshot bit sets `chg_flag` at the next edge. Pins 3..0 and output pins never set it.
- R8: A read (`bus_rd`) or a write (`bus_wr`) at address 0 loads the snapshot from the synchronized pins 7..4 at that edge. The snapshot resets to zero.
- R9: `chg_flag` resets to 0 and is sticky. A `flag_clr` pulse clears it at the next edge, unless a difference is present in that same cycle. In that case the flag stays set, because setting has priority over clearing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 port data, 1 latch, 2 direction, 3 unused |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; only matters at address 0, where it refreshes the snapshot |
| bus_wdata | input | 8 | Write data |
| pin_in | input | 8 | Raw pad input levels |
| pu_ctl_n | input | 1 | Global pull-up control, active low |
| flag_clr | input | 1 | Software clear of the change flag |
| pin_out | output | 8 | Pad drive values (latch) |
| pin_oe | output | 8 | Per-pin output enable |
| pin_pu | output | 8 | Per-pin weak pull-up enable |
| bus_rdata | output | 8 | Read data |
| chg_flag | output | 1 | Change interrupt flag |

## Verification
The hardest situation to create from the ports is a difference that is still present when software clears the flag. In that case the clear must lose, and the flag must then fall only after a port access has refreshed the snapshot. The stimulus first sets a snapshot with a port read. It then toggles an upper input pin, waits out the two synchronizer edges, and pulses `flag_clr` with no port access. Next it reads the port and clears again. It repeats the same steps on lower pins and on upper pins set as outputs, to show that those pins are excluded. Long stretches of random bus traffic and pin activity follow, compared cycle by cycle against the reference model.

// File: rtl/gpio_ioc_pkg.sv
// Package: shared register-select encoding and default sizes for the I/O port.
package gpio_ioc_pkg;

    localparam int unsigned GPIO_W      = 8;
    localparam int unsigned GPIO_ADDR_W = 2;

    // Register selects; the offsets are software-visible.
    typedef enum logic [GPIO_ADDR_W-1:0] {
        SEL_PORT  = 2'd0,
        SEL_LATCH = 2'd1,
        SEL_DIR   = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/gpio_ioc_sync.sv
// Module: gpio_ioc_sync
// A multi-stage synchronizer for a bus of independent pin levels.
// Assumes each bit is an unrelated asynchronous signal; there is no
// bus coherency. The reset value is zero on every stage.
module gpio_ioc_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [STAGES-1:0][W-1:0] chain_q;

    // Shift the raw levels through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= din;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_ioc_regs.sv
// Module: gpio_ioc_regs
// Holds the direction register and the output latch, and decodes the bus.
// Assumes single-cycle strobes. Read data is combinational from the
// address, and pin reads return the synchronized levels. The module also
// flags a port data access (read or write) for the snapshot logic.
module gpio_ioc_regs
    import gpio_ioc_pkg::*;
#(
    parameter int unsigned W      = 8,
    parameter int unsigned ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [W-1:0]      bus_wdata,
    input  logic [W-1:0]      pins_sync,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      latch_q,
    output logic [W-1:0]      bus_rdata,
    output logic              port_access
);

    reg_sel_e sel;
    logic     wr_latch;
    logic     wr_dir;

    // Decode the address into a register select.
    always_comb begin
        sel = reg_sel_e'(bus_addr);
    end

    // Write enables: the port data address and the latch address share the latch.
    always_comb begin
        wr_latch    = bus_wr && ((sel == SEL_PORT) || (sel == SEL_LATCH));
        wr_dir      = bus_wr && (sel == SEL_DIR);
        port_access = (bus_wr || bus_rd) && (sel == SEL_PORT);
    end

    // Direction register; ones mean input, and every pin comes out of reset as an input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '1;
        end else if (wr_dir) begin
            dir_q <= bus_wdata;
        end
    end

    // Output latch, loaded from either data address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (wr_latch) begin
            latch_q <= bus_wdata;
        end
    end

    // Read multiplexer: the port address returns pins, never the latch.
    always_comb begin
        unique case (sel)
            SEL_PORT:  bus_rdata = pins_sync;
            SEL_LATCH: bus_rdata = latch_q;
            SEL_DIR:   bus_rdata = dir_q;
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_ioc_pullup.sv
// Module: gpio_ioc_pullup
// Registers the global active-low pull-up control and gates it per pin
// with the direction bits. Assumes the control is a quasi-static
// configuration bit; one edge of latency is acceptable. Reset holds the
// pull-ups off.
module gpio_ioc_pullup #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pu_ctl_n,
    input  logic [W-1:0] dir_q,
    output logic [W-1:0] pin_pu
);

    logic pu_off_q;

    // Capture the global control; reset state is "disabled".
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pu_off_q <= 1'b1;
        end else begin
            pu_off_q <= pu_ctl_n;
        end
    end

    // Per-pin gating: a pull-up is allowed only on an input pin.
    for (genvar i = 0; i < W; i++) begin : g_pu
        assign pin_pu[i] = !pu_off_q && dir_q[i];
    end

endmodule

// File: rtl/gpio_ioc_change.sv
// Module: gpio_ioc_change
// Change detection on pins W-1..LO. Each pin set as an input is compared
// with a snapshot that is refreshed on every port data access. The ORed
// difference sets a sticky flag. A software clear takes effect only when
// no difference is present in the same cycle, because setting wins.
module gpio_ioc_change #(
    parameter int unsigned W  = 8,
    parameter int unsigned LO = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins_sync,
    input  logic [W-1:0] dir_q,
    input  logic         port_access,
    input  logic         flag_clr,
    output logic         chg_flag
);

    localparam int unsigned NCHG = W - LO;

    logic [NCHG-1:0] snap_q;
    logic [NCHG-1:0] pin_miss;
    logic            any_miss;

    // Snapshot of the watched pins, refreshed on each port data access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (port_access) begin
            snap_q <= pins_sync[W-1:LO];
        end
    end

    // Per-pin difference; a pin set as an output is excluded.
    for (genvar i = 0; i < NCHG; i++) begin : g_cmp
        assign pin_miss[i] = dir_q[LO+i] && (pins_sync[LO+i] != snap_q[i]);
    end

    // OR the per-pin differences together.
    always_comb begin
        any_miss = |pin_miss;
    end

    // Sticky flag: set has priority over the software clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chg_flag <= 1'b0;
        end else if (any_miss) begin
            chg_flag <= 1'b1;
        end else if (flag_clr) begin
            chg_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/gpio_ioc_port.sv
// Module: gpio_ioc_port (top)
// An 8-bit I/O port with a direction register, an output latch, a pin-read
// path, gated weak pull-ups and change detection on the upper pins.
// Assumes that pin_in is asynchronous and that bus strobes last one cycle.
module gpio_ioc_port
    import gpio_ioc_pkg::*;
#(
    parameter int unsigned W      = GPIO_W,
    parameter int unsigned ADDR_W = GPIO_ADDR_W,
    parameter int unsigned SYNC_N = 2,
    parameter int unsigned CHG_LO = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [W-1:0]      bus_wdata,
    input  logic [W-1:0]      pin_in,
    input  logic              pu_ctl_n,
    input  logic              flag_clr,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      pin_oe,
    output logic [W-1:0]      pin_pu,
    output logic [W-1:0]      bus_rdata,
    output logic              chg_flag
);

    logic [W-1:0] pins_sync;
    logic [W-1:0] dir_q;
    logic [W-1:0] latch_q;
    logic         port_access;

    gpio_ioc_sync #(.W(W), .STAGES(SYNC_N)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_in),
        .dout (pins_sync)
    );

    gpio_ioc_regs #(.W(W), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .pins_sync  (pins_sync),
        .dir_q      (dir_q),
        .latch_q    (latch_q),
        .bus_rdata  (bus_rdata),
        .port_access(port_access)
    );

    gpio_ioc_pullup #(.W(W)) u_pullup (
        .clk     (clk),
        .rst_n   (rst_n),
        .pu_ctl_n(pu_ctl_n),
        .dir_q   (dir_q),
        .pin_pu  (pin_pu)
    );

    gpio_ioc_change #(.W(W), .LO(CHG_LO)) u_change (
        .clk        (clk),
        .rst_n      (rst_n),
        .pins_sync  (pins_sync),
        .dir_q      (dir_q),
        .port_access(port_access),
        .flag_clr   (flag_clr),
        .chg_flag   (chg_flag)
    );

    // Pad controls: the latch drives the pin, and a zero direction bit enables the driver.
    always_comb begin
        pin_out = latch_q;
        pin_oe  = ~dir_q;
    end

endmodule

// File: rtl/gpio_ioc_port_chk.sv
// Module: gpio_ioc_port_chk
// Port-level temporal checks for gpio_ioc_port, attached with bind.
module gpio_ioc_port_chk #(
    parameter int unsigned W      = 8,
    parameter int unsigned ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [W-1:0]      bus_wdata,
    input logic              pu_ctl_n,
    input logic              flag_clr,
    input logic [W-1:0]      pin_out,
    input logic [W-1:0]      pin_oe,
    input logic [W-1:0]      pin_pu,
    input logic [W-1:0]      bus_rdata,
    input logic              chg_flag
);

    // R1
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd2) |=> (pin_oe == ~$past(bus_wdata)));

    // R2
    latch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr <= 2'd1) |=> (pin_out == $past(bus_wdata)));

    // R3
    unused_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd3) |-> (bus_rdata == '0));

    // R5
    pu_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_pu & pin_oe) == '0));

    // R6
    pu_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pu_ctl_n |=> (pin_pu == '0));

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_flag && !flag_clr) |=> chg_flag);

endmodule

bind gpio_ioc_port gpio_ioc_port_chk #(.W(W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .pu_ctl_n (pu_ctl_n),
    .flag_clr (flag_clr),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .pin_pu   (pin_pu),
    .bus_rdata(bus_rdata),
    .chg_flag (chg_flag)
);

// File: tb/gpio_ioc_port_test.sv
// Bench: directed and random stimulus. A behavioural reference model
// updates on every rising edge and is compared with the outputs on every
// falling edge.
module gpio_ioc_port_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] pin_in = '0;
    logic       pu_ctl_n = 1'b1;
    logic       flag_clr = 1'b0;
    logic [7:0] pin_out, pin_oe, pin_pu, bus_rdata;
    logic       chg_flag;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    always #10 clk = ~clk;   // 50 MHz

    gpio_ioc_port uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .pin_in(pin_in),
        .pu_ctl_n(pu_ctl_n), .flag_clr(flag_clr), .pin_out(pin_out),
        .pin_oe(pin_oe), .pin_pu(pin_pu), .bus_rdata(bus_rdata),
        .chg_flag(chg_flag)
    );

    // Reference model state
    logic [7:0] m_s1, m_s2, m_dir, m_lat;
    logic [3:0] m_snap;
    logic       m_flag, m_puoff;

    always @(posedge clk) begin
        logic       diff;
        logic [7:0] n_s1, n_s2, n_dir, n_lat;
        logic [3:0] n_snap;
        logic       n_flag, n_puoff;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_dir = 8'hFF; m_lat = 0;
            m_snap = 0; m_flag = 0; m_puoff = 1;
        end else begin
            diff = 0;
            for (int k = 4; k < 8; k++)
                if (m_dir[k] && (m_s2[k] != m_snap[k-4])) diff = 1;
            n_s1 = pin_in; n_s2 = m_s1;
            n_dir = m_dir; n_lat = m_lat; n_snap = m_snap; n_puoff = pu_ctl_n;
            if (bus_wr && bus_addr == 2) n_dir = bus_wdata;
            if (bus_wr && (bus_addr == 0 || bus_addr == 1)) n_lat = bus_wdata;
            if ((bus_wr || bus_rd) && bus_addr == 0) n_snap = m_s2[7:4];
            if (diff) n_flag = 1;
            else if (flag_clr) n_flag = 0;
            else n_flag = m_flag;
            m_s1 = n_s1; m_s2 = n_s2; m_dir = n_dir; m_lat = n_lat;
            m_snap = n_snap; m_flag = n_flag; m_puoff = n_puoff;
        end
    end

    task automatic cmp8(input string req, input string nm, input logic [7:0] act, input logic [7:0] exp);
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, nm, act, exp, $time);
        end
    endtask

    // Compare every output with the model
    task automatic check_all();
        logic [7:0] e_rd;
        case (bus_addr)
            2'd0: e_rd = m_s2;
            2'd1: e_rd = m_lat;
            2'd2: e_rd = m_dir;
            default: e_rd = 8'h00;
        endcase
        vectors++;
        cmp8("R2", "pin_out", pin_out, m_lat);
        cmp8("R1", "pin_oe", pin_oe, ~m_dir);
        cmp8("R5/R6", "pin_pu", pin_pu, m_puoff ? 8'h00 : m_dir);
        cmp8(bus_addr == 0 ? "R4" : "R3", "bus_rdata", bus_rdata, e_rd);
        cmp8("R7/R9", "chg_flag", {7'b0, chg_flag}, {7'b0, m_flag});
    endtask

    // One cycle: check the settled state, then drive the next inputs
    task automatic step(input logic [1:0] a, input logic wr, input logic rd,
                        input logic [7:0] wd, input logic clr);
        @(negedge clk);
        check_all();
        bus_addr = a; bus_wr = wr; bus_rd = rd; bus_wdata = wd; flag_clr = clr;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(2'd3, 0, 0, 8'h00, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 R2 R6: reset state
        idle(2);
        // R1 R3: direction, latch via both addresses, readback
        step(2'd2, 1, 0, 8'h0F, 0);
        step(2'd0, 1, 0, 8'hA5, 0);
        step(2'd1, 0, 1, 8'h00, 0);
        step(2'd1, 1, 0, 8'h3C, 0);
        step(2'd1, 0, 1, 8'h00, 0);
        step(2'd2, 0, 1, 8'h00, 0);
        step(2'd3, 0, 1, 8'h00, 0);
        // R4: pins seen at address 0 after synchronizer, not latch
        pin_in = 8'h5A;
        step(2'd0, 0, 0, 8'h00, 0);
        step(2'd0, 0, 0, 8'h00, 0);
        step(2'd0, 0, 0, 8'h00, 0);
        // R5 R6: pull-ups
        pu_ctl_n = 1'b0; idle(2);
        pu_ctl_n = 1'b1; idle(2);
        pu_ctl_n = 1'b0;
        // R7 R8 R9: change flag with clear while the difference persists
        step(2'd2, 1, 0, 8'hFF, 0);
        pin_in = 8'h00; idle(3);
        step(2'd0, 0, 1, 8'h00, 0);
        step(2'd0, 0, 0, 8'h00, 1);
        idle(2);
        pin_in = 8'h40; idle(4);
        step(2'd3, 0, 0, 8'h00, 1);   // clear loses, R9
        idle(2);
        step(2'd0, 0, 1, 8'h00, 0);   // R8 refresh
        step(2'd3, 0, 0, 8'h00, 1);
        idle(3);
        // R7: lower pins are ignored
        pin_in = 8'h4F; idle(4);
        // R7: upper pins set as outputs are ignored
        step(2'd2, 1, 0, 8'h0F, 0);
        pin_in = 8'hB0; idle(4);
        step(2'd0, 1, 0, 8'h11, 0);   // R8 write also refreshes the snapshot
        step(2'd2, 1, 0, 8'hFF, 0);
        idle(4);
        // Random traffic
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 9) == 0) pin_in = 8'($urandom);
            if ($urandom_range(0, 49) == 0) pu_ctl_n = ~pu_ctl_n;
            step(2'($urandom), ($urandom_range(0, 5) == 0), ($urandom_range(0, 4) == 0),
                 8'($urandom), ($urandom_range(0, 7) == 0));
        end
        idle(2);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule